// File: doc/BRIEF.md
# Fixed-Priority Nested Interrupt Controller

This block gathers fourteen interrupt sources and offers the CPU the most urgent one that is pending, enabled and allowed to preempt the current service level. Seven sources come from pins. Six general pins each have their own choice of rising or falling edge. One hold pin reacts to falling edges only. The other seven sources are single-cycle request pulses from inside the chip: three from the serial ports and four from the timers.

The CPU takes the offered request with an acknowledge. The acknowledge clears the source's pending flag and pushes the source onto an in-service stack. A return pops the stack. A new request interrupts the running handler only if its priority is strictly higher. The stack has a parameterised depth, 16 by default. While the stack is full, requests wait. A separate wake output tells the halt logic that an enabled request is pending.

Top module: `prio_nest_irq`

## Requirements
- R1: After reset, `irq_valid` is 0, `nest_level` is 0 and `wake` is 0.
- R2: General pin k (0..5) raises source 1+k on the edge selected by `pin_rise[k]`: 1 selects rising and 0 selects falling. The opposite edge raises nothing. A pin change made before clock edge n shows on `irq_valid` after edge n+2.
- R3: The hold pin raises source 0 on a falling edge only. A rising edge on it raises nothing.
- R4: A one-cycle pulse on `int_pulse[j]` raises source 7+j. Bits 0..2 are the serial ports and bits 3..6 are timers 0..3. The request is visible after the next clock edge.
- R5: `irq_vec` gives the lowest-numbered eligible source. Number 0 is the most urgent and number 13 the least.
- R6: A pending source whose `src_en` bit is 0 stays pending but is not offered. It is offered once the bit is set.
- R7: `ack` while `irq_valid` is 1 clears that source's pending flag and raises `nest_level` by one. `ack` while `irq_valid` is 0 is ignored.
- R8: While a level is in service, only sources with a strictly smaller number than the one on top of the stack are offered. A request of the same or a lower priority waits for `reti`.
- R9: At `nest_level` equal to NEST_DEPTH, `irq_valid` is 0. A `reti` pops one level, and the highest pending request is then offered again.
- R10: `reti` lowers `nest_level` by one only when the level is above zero and no acknowledge is accepted in the same cycle. In all other cases it is ignored.
- R11: `wake` is 1 whenever any enabled source is pending, including a source held back by nesting or by a full stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hold_n | input | 1 | Hold pin, falling-edge request (source 0) |
| pin_in | input | N_PINS | General interrupt pins (sources 1..6) |
| pin_rise | input | N_PINS | Per-pin edge select: 1 rising, 0 falling |
| int_pulse | input | N_INT | Internal request pulses (sources 7..13) |
| src_en | input | N_PINS+N_INT+1 | Per-source enable, bit = source number |
| ack | input | 1 | CPU accepts the offered request |
| reti | input | 1 | CPU returns from the current handler |
| irq_valid | output | 1 | A request is offered |
| irq_vec | output | 4 | Number of the offered source |
| nest_level | output | $clog2(NEST_DEPTH+1) | Count of levels in service |
| wake | output | 1 | An enabled request is pending (halt release) |

## Verification
The hardest state to reach is a completely full in-service stack. Because preemption needs strictly higher priority, each push needs a more urgent source than the previous one. The bench therefore builds a reduced configuration with a depth of four. It raises timer sources in rising order of urgency and acknowledges each one. It then checks that a serial request waits with `wake` high until a return frees a level. An exhaustive sweep over pairs of internal sources covers priority order, blocking of equal and lower priorities, and release on return.

// File: rtl/prio_nest_irq.sv
module prio_nest_irq #(
  parameter int NEST_DEPTH = 16,
  parameter int N_PINS     = 6,
  parameter int N_INT      = 7
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              hold_n,
  input  logic [N_PINS-1:0]                 pin_in,
  input  logic [N_PINS-1:0]                 pin_rise,
  input  logic [N_INT-1:0]                  int_pulse,
  input  logic [N_PINS+N_INT:0]             src_en,
  input  logic                              ack,
  input  logic                              reti,
  output logic                              irq_valid,
  output logic [$clog2(N_PINS+N_INT+1)-1:0] irq_vec,
  output logic [$clog2(NEST_DEPTH+1)-1:0]   nest_level,
  output logic                              wake
);
  localparam int NSRC = N_PINS + N_INT + 1;
  localparam int VW   = $clog2(NSRC);
  localparam int LW   = $clog2(NEST_DEPTH+1);
  localparam logic [N_PINS:0] SYNC_INIT = {{N_PINS{1'b0}}, 1'b1};

  logic [N_PINS:0] s1, s2, s3, ext_edge;
  logic [NSRC-1:0] pending, cand, set_v, clr_v;
  logic [VW-1:0]   stk [NEST_DEPTH];
  logic [VW-1:0]   top;
  logic [LW-1:0]   lvl;
  logic            take, pop, full;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= SYNC_INIT;
      s2 <= SYNC_INIT;
      s3 <= SYNC_INIT;
    end else begin
      s1 <= {pin_in, hold_n};
      s2 <= s1;
      s3 <= s2;
    end

  assign ext_edge[0] = s3[0] & ~s2[0];
  for (genvar g = 1; g <= N_PINS; g++) begin : g_edge
    assign ext_edge[g] = pin_rise[g-1] ? (s2[g] & ~s3[g]) : (~s2[g] & s3[g]);
  end

  assign set_v = {int_pulse, ext_edge};
  assign full  = (lvl == LW'(NEST_DEPTH));
  assign top   = (lvl == '0) ? '0 : stk[int'(lvl) - 1];

  always_comb begin
    for (int i = 0; i < NSRC; i++)
      cand[i] = pending[i] & src_en[i] & ~full & ((lvl == '0) || (VW'(i) < top));
    irq_vec = '0;
    for (int i = NSRC-1; i >= 0; i--)
      if (cand[i]) irq_vec = VW'(i);
  end

  assign irq_valid  = |cand;
  assign wake       = |(pending & src_en);
  assign take       = ack & irq_valid;
  assign pop        = reti & ~take & (lvl != '0);
  assign clr_v      = take ? (NSRC'(1) << irq_vec) : '0;
  assign nest_level = lvl;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pending <= '0;
      lvl     <= '0;
      for (int i = 0; i < NEST_DEPTH; i++) stk[i] <= '0;
    end else begin
      pending <= (pending & ~clr_v) | set_v;
      if (take) begin
        stk[int'(lvl)] <= irq_vec;
        lvl <= lvl + 1'b1;
      end else if (pop) begin
        lvl <= lvl - 1'b1;
      end
    end
endmodule

// File: rtl/prio_nest_irq_chk.sv
module prio_nest_irq_chk #(
  parameter int NEST_DEPTH = 16,
  parameter int NSRC       = 14,
  parameter int VW         = 4,
  parameter int LW         = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ack,
  input logic            reti,
  input logic [NSRC-1:0] src_en,
  input logic            irq_valid,
  input logic [VW-1:0]   irq_vec,
  input logic [LW-1:0]   nest_level,
  input logic [VW-1:0]   top_vec,
  input logic            wake
);
  AST_VEC_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> src_en[irq_vec]); // R6
  AST_ACK_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_valid) |=> nest_level == $past(nest_level) + 1'b1); // R7
  AST_STRICT_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && nest_level != '0) |-> irq_vec < top_vec); // R8
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (nest_level == LW'(NEST_DEPTH)) |-> !irq_valid); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    nest_level <= LW'(NEST_DEPTH)); // R9
  AST_RETI_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !(ack && irq_valid) && nest_level != '0) |=> nest_level == $past(nest_level) - 1'b1); // R10
  AST_WAKE_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> wake); // R11
endmodule

bind prio_nest_irq prio_nest_irq_chk #(
  .NEST_DEPTH(NEST_DEPTH), .NSRC(NSRC), .VW(VW), .LW(LW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .ack(ack), .reti(reti), .src_en(src_en),
  .irq_valid(irq_valid), .irq_vec(irq_vec), .nest_level(nest_level),
  .top_vec(top), .wake(wake)
);

// File: tb/prio_nest_irq_tb_top.sv
`timescale 1ns/1ps
module prio_nest_irq_tb_top;
  localparam int DEPTH = 4;
  logic clk = 0, rst_n = 0, hold_n = 1, ack = 0, reti = 0;
  logic [5:0]  pin_in = '0, pin_rise = '0;
  logic [6:0]  int_pulse = '0;
  logic [13:0] src_en = '1;
  logic        irq_valid, wake;
  logic [3:0]  irq_vec;
  logic [2:0]  nest_level;
  int tests = 0, fails = 0;
  bit done = 0;

  prio_nest_irq #(.NEST_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .hold_n(hold_n), .pin_in(pin_in), .pin_rise(pin_rise),
    .int_pulse(int_pulse), .src_en(src_en), .ack(ack), .reti(reti),
    .irq_valid(irq_valid), .irq_vec(irq_vec), .nest_level(nest_level), .wake(wake));

  always #10 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(logic [6:0] m);
    int_pulse = m; cyc(1); int_pulse = '0;
  endtask

  task automatic do_ack;
    ack = 1; cyc(1); ack = 0;
  endtask

  task automatic do_reti;
    reti = 1; cyc(1); reti = 0;
  endtask

  initial begin
    cyc(2);
    chk("R1 valid", irq_valid, 0); chk("R1 level", nest_level, 0); chk("R1 wake", wake, 0);
    rst_n = 1; cyc(2);
    chk("R1 valid after release", irq_valid, 0);

    for (int k = 0; k < 6; k++) begin
      for (int pol = 0; pol < 2; pol++) begin
        pin_rise[k] = pol[0];
        if (pol == 0) begin
          pin_in[k] = 1; cyc(4);
          chk("R2 opposite edge ignored", irq_valid, 0);
          pin_in[k] = 0;
        end else begin
          pin_in[k] = 1;
        end
        cyc(2); chk("R2 latency", irq_valid, 0);
        cyc(1); chk("R2 valid", irq_valid, 1); chk("R2 vec", irq_vec, 1 + k);
        do_ack; chk("R7 level", nest_level, 1); chk("R7 cleared", irq_valid, 0);
        do_reti; chk("R10 pop", nest_level, 0); chk("R7 no repeat", irq_valid, 0);
        if (pol == 1) begin
          pin_in[k] = 0; cyc(4);
          chk("R2 falling ignored in rise mode", irq_valid, 0);
        end
      end
    end

    hold_n = 0; cyc(2); chk("R3 latency", irq_valid, 0);
    cyc(1); chk("R3 valid", irq_valid, 1); chk("R3 vec", irq_vec, 0);
    do_ack; do_reti;
    hold_n = 1; cyc(4); chk("R3 rising ignored", irq_valid, 0);

    for (int j = 0; j < 7; j++) begin
      pulse(7'(1 << j));
      chk("R4 vec", irq_vec, 7 + j); chk("R4 valid", irq_valid, 1);
      do_ack; do_reti;
    end

    for (int a = 0; a < 7; a++)
      for (int b = a + 1; b < 7; b++) begin
        pulse(7'((1 << a) | (1 << b)));
        chk("R5 winner", irq_vec, 7 + a);
        do_ack; chk("R8 lower waits", irq_valid, 0); chk("R11 wake", wake, 1);
        pulse(7'(1 << a)); chk("R8 equal waits", irq_valid, 0);
        do_reti; chk("R8 released equal", irq_vec, 7 + a);
        do_ack; do_reti; chk("R8 released lower", irq_vec, 7 + b);
        do_ack; do_reti; chk("R8 drained", irq_valid, 0);
      end

    src_en[10] = 0; pulse(7'b0001000);
    chk("R6 masked", irq_valid, 0); chk("R11 wake masked", wake, 0);
    cyc(3); src_en[10] = 1; cyc(1);
    chk("R6 offered after enable", irq_vec, 10); chk("R6 valid", irq_valid, 1);
    do_ack; do_reti;

    do_ack; chk("R7 ack ignored", nest_level, 0);
    do_reti; chk("R10 reti at zero", nest_level, 0);
    pulse(7'b0000100);
    ack = 1; reti = 1; cyc(1); ack = 0; reti = 0;
    chk("R10 ack wins", nest_level, 1);
    do_reti;

    for (int t = 6; t >= 3; t--) begin
      pulse(7'(1 << t)); chk("R9 fill vec", irq_vec, 7 + t); do_ack;
    end
    chk("R9 full level", nest_level, DEPTH);
    pulse(7'b0000001);
    chk("R9 full blocks", irq_valid, 0); chk("R11 wake when full", wake, 1);
    do_reti; chk("R9 pop level", nest_level, DEPTH - 1);
    chk("R9 offered after pop", irq_vec, 7);
    do_ack; repeat (4) do_reti;
    chk("R10 drained", nest_level, 0);

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1; tests++; fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule